// File: doc/BRIEF.md
# Program Memory Dual Parity Guard

This block sits beside the instruction fetch path and checks every fetched program word against the two parity bits stored with it. The word is split into two interleaved lanes. The lane holding bit positions 0, 2, 4 and so on is protected by an even-parity bit. The lane holding positions 1, 3, 5 and so on is protected by an odd-parity bit. When either lane disagrees with its stored bit, the block asks for a full device reset and drops an active-low error status bit. It records nothing about where the failure happened.

The status bit returns high only in two ways: when software writes it, or when power-on reset is applied. The ordinary system reset, including the reset that the block itself requests, leaves the status bit alone. Software can therefore read it after restart and learn that a parity fault caused the restart.

A separate encoder port computes the two parity bits for any word, for use at programming time. Any word encoded this way passes the check.

Fetches arrive on a valid/ready pair. A word counts as accepted only in a cycle where both `fetch_valid` and `fetch_ready` are high. While ready is low, the source must hold the word and its parity bits steady and keep valid high. Ready goes low during system reset and for the single cycle in which a reset request is being issued.

Top module: `pmem_parity_guard`

## Requirements
- R1: `enc_par[0]` equals the XOR of word bits 0,2,…,12. `enc_par[1]` equals the inverse of the XOR of word bits 1,3,…,13.
- R2: An accepted fetch, with checking enabled, whose even lane (bits 0,2,…,12 XOR `fetch_par[0]`) is nonzero makes `parity_rst_req` high for exactly one cycle. That cycle is the one after the accepting clock edge.
- R3: An accepted fetch, with checking enabled, whose odd lane fails makes `parity_rst_req` high for exactly one cycle, in the same cycle as R2. The odd lane fails when the inverted `fetch_par[1]` XOR bits 1,3,…,13 is nonzero.
- R4: An accepted fetch whose parity matches the R1 encoding raises no request and leaves `perr_n` unchanged.
- R5: When `cfg_par_en` (the value of configuration bit 7: 1 = enabled, 0 = disabled) is 0, corrupt fetches raise no request and leave `perr_n` unchanged.
- R6: A word presented while `fetch_valid` is low is not checked.
- R7: `perr_n` falls to 0 at the same clock edge that raises `parity_rst_req`.
- R8: A write with `sw_wr_en` high loads `perr_n` from `sw_wr_data` at the next edge. If a detection occurs in the same cycle, the detection wins and `perr_n` becomes 0.
- R9: `por_n` low forces `perr_n` to 1 and `parity_rst_req` to 0. `sys_rst_n` low clears `parity_rst_req` and holds `fetch_ready` low, but leaves `perr_n` unchanged.
- R10: `fetch_ready` is low in the cycle in which `parity_rst_req` is high. A fetch held through that cycle is accepted only in the following cycle.
- R11: A word failing both lanes produces one single-cycle request, as for a single-lane failure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| sys_rst_n | input | 1 | System reset, active low, asynchronous; does not touch the status bit |
| cfg_par_en | input | 1 | Configuration bit 7: 1 enables checking |
| fetch_valid | input | 1 | Fetched word is present |
| fetch_ready | output | 1 | Guard can accept the word this cycle |
| fetch_word | input | 14 | Fetched program word |
| fetch_par | input | 2 | Stored parity: bit 0 even lane, bit 1 odd lane |
| sw_wr_en | input | 1 | Software write strobe for the status bit |
| sw_wr_data | input | 1 | Value written to the status bit |
| parity_rst_req | output | 1 | One-cycle reset request on a parity fault |
| perr_n | output | 1 | Parity error status, 0 after a fault |
| enc_word | input | 14 | Word to encode at programming time |
| enc_par | output | 2 | Parity bits computed for `enc_word` |

## Verification
Two functions can land in the same cycle. One is a software write to the status bit. The other is the detection of a corrupt accepted fetch. The collision is provoked by driving `sw_wr_en` high with data 1 in the same cycle as an accepted corrupt word. It is judged by requiring `perr_n` to read 0 and `parity_rst_req` to read 1 one cycle later. A second overlap also needs care: a corrupt fetch held during the request cycle. That case is judged by requiring a low request in the stalled cycle and a second pulse one cycle after that.

// File: rtl/pmpar_pkg.sv
package pmpar_pkg;

  // Stored parity pair: odd lane in bit 1, even lane in bit 0.
  typedef struct packed {
    logic odd_p;
    logic even_p;
  } par_pair_t;

endpackage

// File: rtl/pmpar_encode.sv
module pmpar_encode
  import pmpar_pkg::*;
#(
  parameter int unsigned WORD_W = 14
) (
  input  logic [WORD_W-1:0] word,
  output par_pair_t         par
);

  logic [WORD_W-1:0] lane_even;
  logic [WORD_W-1:0] lane_odd;

  // Split the word into its two interleaved lanes.
  for (genvar i = 0; i < WORD_W; i++) begin : g_lane
    if ((i % 2) == 0) begin : g_even
      assign lane_even[i] = word[i];
      assign lane_odd[i]  = 1'b0;
    end else begin : g_odd
      assign lane_even[i] = 1'b0;
      assign lane_odd[i]  = word[i];
    end
  end

  // The even lane plus its bit holds an even count of ones.
  assign par.even_p = ^lane_even;
  // The odd lane plus its bit holds an odd count of ones.
  assign par.odd_p  = ~(^lane_odd);

endmodule

// File: rtl/pmpar_check.sv
module pmpar_check
  import pmpar_pkg::*;
#(
  parameter int unsigned WORD_W = 14
) (
  input  logic [WORD_W-1:0] word,
  input  par_pair_t         stored,
  output logic              err_even,
  output logic              err_odd
);

  par_pair_t calc;

  pmpar_encode #(.WORD_W(WORD_W)) u_recalc (
    .word (word),
    .par  (calc)
  );

  // Syndrome per lane: a nonzero value means the lane disagrees with its stored bit.
  assign err_even = stored.even_p ^ calc.even_p;
  assign err_odd  = stored.odd_p  ^ calc.odd_p;

endmodule

// File: rtl/pmpar_status.sv
module pmpar_status (
  input  logic clk,
  input  logic por_n,
  input  logic sys_rst_n,
  input  logic fault_hit,
  input  logic sw_wr_en,
  input  logic sw_wr_data,
  output logic rst_req,
  output logic perr_n
);

  logic req_q;
  logic flag_q;

  // Request pulse: cleared by either reset, lasts one cycle.
  always_ff @(posedge clk or negedge por_n or negedge sys_rst_n) begin
    if (!por_n || !sys_rst_n) begin
      req_q <= 1'b0;
    end else begin
      req_q <= fault_hit;
    end
  end

  // Status flag: survives system reset, only power-on or software change it.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      flag_q <= 1'b1;
    end else if (fault_hit) begin
      flag_q <= 1'b0;
    end else if (sw_wr_en) begin
      flag_q <= sw_wr_data;
    end
  end

  assign rst_req = req_q;
  assign perr_n  = flag_q;

endmodule

// File: rtl/pmem_parity_guard.sv
module pmem_parity_guard
  import pmpar_pkg::*;
#(
  parameter int unsigned WORD_W = 14,
  parameter int unsigned PAR_W  = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              sys_rst_n,
  input  logic              cfg_par_en,
  input  logic              fetch_valid,
  output logic              fetch_ready,
  input  logic [WORD_W-1:0] fetch_word,
  input  logic [PAR_W-1:0]  fetch_par,
  input  logic              sw_wr_en,
  input  logic              sw_wr_data,
  output logic              parity_rst_req,
  output logic              perr_n,
  input  logic [WORD_W-1:0] enc_word,
  output logic [PAR_W-1:0]  enc_par
);

  par_pair_t stored;
  par_pair_t enc_pair;
  logic      err_even;
  logic      err_odd;
  logic      accept;
  logic      fault_hit;

  assign stored = par_pair_t'(fetch_par);

  pmpar_check #(.WORD_W(WORD_W)) u_check (
    .word     (fetch_word),
    .stored   (stored),
    .err_even (err_even),
    .err_odd  (err_odd)
  );

  pmpar_encode #(.WORD_W(WORD_W)) u_enc (
    .word (enc_word),
    .par  (enc_pair)
  );
  assign enc_par = PAR_W'(enc_pair);

  assign fetch_ready = sys_rst_n & ~parity_rst_req;
  assign accept      = fetch_valid & fetch_ready;
  assign fault_hit   = accept & cfg_par_en & (err_even | err_odd);

  pmpar_status u_status (
    .clk        (clk),
    .por_n      (por_n),
    .sys_rst_n  (sys_rst_n),
    .fault_hit  (fault_hit),
    .sw_wr_en   (sw_wr_en),
    .sw_wr_data (sw_wr_data),
    .rst_req    (parity_rst_req),
    .perr_n     (perr_n)
  );

endmodule

// File: rtl/pmpar_guard_chk.sv
module pmpar_guard_chk #(
  parameter int unsigned WORD_W = 14,
  parameter int unsigned PAR_W  = 2
) (
  input logic              clk,
  input logic              por_n,
  input logic              sys_rst_n,
  input logic              cfg_par_en,
  input logic              fetch_valid,
  input logic              fetch_ready,
  input logic [WORD_W-1:0] fetch_word,
  input logic [PAR_W-1:0]  fetch_par,
  input logic              sw_wr_en,
  input logic              parity_rst_req,
  input logic              perr_n
);

  logic mismatch;
  logic bad_accept;

  // Independent lane sums taken straight from the ports.
  always_comb begin
    logic se;
    logic so;
    se = fetch_par[0];
    so = ~fetch_par[1];
    for (int i = 0; i < WORD_W; i++) begin
      if ((i % 2) == 0) se = se ^ fetch_word[i];
      else              so = so ^ fetch_word[i];
    end
    mismatch = se | so;
  end

  assign bad_accept = fetch_valid && fetch_ready && cfg_par_en && mismatch;

  a_r2_fault_raises_req: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    bad_accept |=> (parity_rst_req && !perr_n));

  a_r11_req_single_cycle: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    parity_rst_req |=> !parity_rst_req);

  a_r7_flag_low_with_req: assert property (@(posedge clk) disable iff (!por_n)
    parity_rst_req |-> !perr_n);

  a_r5_disabled_quiet: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    (fetch_valid && fetch_ready && !cfg_par_en) |=> !parity_rst_req);

  a_r10_stall_during_req: assert property (@(posedge clk) disable iff (!por_n)
    parity_rst_req |-> !fetch_ready);

  a_r4_flag_holds: assert property (@(posedge clk) disable iff (!por_n)
    (!sw_wr_en && !bad_accept) |=> $stable(perr_n));

endmodule

bind pmem_parity_guard pmpar_guard_chk #(.WORD_W(WORD_W), .PAR_W(PAR_W)) u_guard_chk (
  .clk            (clk),
  .por_n          (por_n),
  .sys_rst_n      (sys_rst_n),
  .cfg_par_en     (cfg_par_en),
  .fetch_valid    (fetch_valid),
  .fetch_ready    (fetch_ready),
  .fetch_word     (fetch_word),
  .fetch_par      (fetch_par),
  .sw_wr_en       (sw_wr_en),
  .parity_rst_req (parity_rst_req),
  .perr_n         (perr_n)
);

// File: tb/pmem_parity_guard_bench.sv
module pmem_parity_guard_bench;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        sys_rst_n = 1'b0;
  logic        cfg_par_en = 1'b1;
  logic        fetch_valid = 1'b0;
  logic        fetch_ready;
  logic [13:0] fetch_word = '0;
  logic [1:0]  fetch_par = '0;
  logic        sw_wr_en = 1'b0;
  logic        sw_wr_data = 1'b0;
  logic        parity_rst_req;
  logic        perr_n;
  logic [13:0] enc_word = '0;
  logic [1:0]  enc_par;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  pmem_parity_guard u_pmem_parity_guard (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .cfg_par_en(cfg_par_en),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .fetch_word(fetch_word),
    .fetch_par(fetch_par), .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
    .parity_rst_req(parity_rst_req), .perr_n(perr_n),
    .enc_word(enc_word), .enc_par(enc_par)
  );

  function automatic logic [1:0] ref_par(input logic [13:0] w);
    logic e = 1'b0;
    logic o = 1'b0;
    for (int i = 0; i < 14; i++) begin
      if (i % 2 == 0) e ^= w[i];
      else            o ^= w[i];
    end
    return {~o, e};
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Present one word for one accepting edge, return at the next falling edge.
  task automatic do_fetch(input logic [13:0] w, input logic [1:0] p);
    @(negedge clk);
    fetch_word = w; fetch_par = p; fetch_valid = 1'b1;
    @(negedge clk);
    fetch_valid = 1'b0;
  endtask

  task automatic sw_write(input logic d);
    @(negedge clk);
    sw_wr_en = 1'b1; sw_wr_data = d;
    @(negedge clk);
    sw_wr_en = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R9 reset perr_n", 16'(perr_n), 16'd1);
    chk("R9 reset req", 16'(parity_rst_req), 16'd0);
    chk("R10 reset ready", 16'(fetch_ready), 16'd1);
  endtask

  task automatic t_encoder();
    logic [13:0] words [5] = '{14'h0000, 14'h3FFF, 14'h1555, 14'h2AAA, 14'h1234};
    foreach (words[k]) begin
      enc_word = words[k];
      #1;
      chk("R1 encoder", 16'(enc_par), 16'(ref_par(words[k])));
    end
  endtask

  task automatic t_clean();
    logic [13:0] words [4] = '{14'h0000, 14'h3FFF, 14'h0A5C, 14'h2001};
    foreach (words[k]) begin
      do_fetch(words[k], ref_par(words[k]));
      chk("R4 clean req", 16'(parity_rst_req), 16'd0);
      chk("R4 clean perr_n", 16'(perr_n), 16'd1);
    end
  endtask

  task automatic flip_and_judge(input string tag, input logic [13:0] w, input logic [1:0] p);
    do_fetch(w, p);
    chk({tag, " req"}, 16'(parity_rst_req), 16'd1);
    chk({tag, " R7 perr_n"}, 16'(perr_n), 16'd0);
    @(negedge clk);
    chk({tag, " one-cycle"}, 16'(parity_rst_req), 16'd0);
    sw_write(1'b1);
    chk("R8 sw restore", 16'(perr_n), 16'd1);
  endtask

  task automatic t_even_flip();
    logic [13:0] base = 14'h19C3;
    int pos [3] = '{0, 6, 12};
    foreach (pos[k]) flip_and_judge("R2 even", base ^ (14'd1 << pos[k]), ref_par(base));
    flip_and_judge("R2 even parbit", base, ref_par(base) ^ 2'b01);
  endtask

  task automatic t_odd_flip();
    logic [13:0] base = 14'h2E51;
    int pos [3] = '{1, 7, 13};
    foreach (pos[k]) flip_and_judge("R3 odd", base ^ (14'd1 << pos[k]), ref_par(base));
    flip_and_judge("R3 odd parbit", base, ref_par(base) ^ 2'b10);
  endtask

  task automatic t_both();
    flip_and_judge("R11 both", 14'h0703 ^ 14'h0003, ref_par(14'h0703));
  endtask

  task automatic t_disabled();
    cfg_par_en = 1'b0;
    do_fetch(14'h0101, ref_par(14'h0101) ^ 2'b11);
    chk("R5 disabled req", 16'(parity_rst_req), 16'd0);
    @(negedge clk);
    chk("R5 disabled perr_n", 16'(perr_n), 16'd1);
    cfg_par_en = 1'b1;
  endtask

  task automatic t_novalid();
    @(negedge clk);
    fetch_word = 14'h0001; fetch_par = ref_par(14'h0000);
    fetch_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk("R6 novalid req", 16'(parity_rst_req), 16'd0);
    chk("R6 novalid perr_n", 16'(perr_n), 16'd1);
  endtask

  task automatic t_collision();
    @(negedge clk);
    fetch_word = 14'h0004; fetch_par = ref_par(14'h0000); fetch_valid = 1'b1;
    sw_wr_en = 1'b1; sw_wr_data = 1'b1;
    @(negedge clk);
    fetch_valid = 1'b0; sw_wr_en = 1'b0;
    chk("R8 collision perr_n", 16'(perr_n), 16'd0);
    chk("R8 collision req", 16'(parity_rst_req), 16'd1);
    sw_write(1'b1);
    sw_write(1'b0);
    chk("R8 sw write 0", 16'(perr_n), 16'd0);
    sw_write(1'b1);
    chk("R8 sw write 1", 16'(perr_n), 16'd1);
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    fetch_word = 14'h0010; fetch_par = ref_par(14'h0000); fetch_valid = 1'b1;
    @(negedge clk);
    chk("R10 first req", 16'(parity_rst_req), 16'd1);
    chk("R10 ready low", 16'(fetch_ready), 16'd0);
    @(negedge clk);
    chk("R10 stalled no req", 16'(parity_rst_req), 16'd0);
    chk("R10 ready back", 16'(fetch_ready), 16'd1);
    @(negedge clk);
    fetch_valid = 1'b0;
    chk("R10 held word pulses", 16'(parity_rst_req), 16'd1);
    @(negedge clk);
    sw_write(1'b1);
  endtask

  task automatic t_resets();
    do_fetch(14'h0020, ref_par(14'h0000));
    @(negedge clk);
    sys_rst_n = 1'b0;
    @(negedge clk);
    chk("R9 sysrst ready", 16'(fetch_ready), 16'd0);
    chk("R9 sysrst keeps perr_n", 16'(perr_n), 16'd0);
    sys_rst_n = 1'b1;
    @(negedge clk);
    chk("R9 after sysrst perr_n", 16'(perr_n), 16'd0);
    por_n = 1'b0;
    @(negedge clk);
    chk("R9 por sets perr_n", 16'(perr_n), 16'd1);
    chk("R9 por req", 16'(parity_rst_req), 16'd0);
    por_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1; sys_rst_n = 1'b1;
    t_reset();
    t_encoder();
    t_clean();
    t_even_flip();
    t_odd_flip();
    t_both();
    t_disabled();
    t_novalid();
    t_collision();
    t_backpressure();
    t_resets();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule